// File: doc/BRIEF.md
# Poisoned Line Range Tracker

This block keeps a bounded table of memory ranges known to hold bad data. Each entry has a start line (addresses are in 64-byte line units), a length in lines and a 3-bit origin code. A single request port takes four operations. Inject marks one line as bad. Clear repairs one line. Query lists every tracked range that touches a window. Log records a multi-line range found by another agent, such as a scrubber.

A clear that hits the middle of a range cuts that range into a part below the repaired line and a part above it. When the part above has no free slot, the table sets a sticky overflow indication and keeps the current timestamp, and the clear still succeeds. The table is scanned one slot per cycle. `busy` stays high during the scan. Query results come out as a stream of records, one per cycle, followed by a single completion pulse that carries the status and the record count.

Top module: `poison_table`

## Requirements
- R1: After reset the table holds no entries, `busy`, `rsp_done` and `rec_valid` are low, and `rsp_flags` is zero; a query then reports 0 records.
- R2: Inject (`req_op`=0) of address A adds an entry of start line A/64, length 1 and origin code 3'b010 in the lowest-numbered free slot, and completes with status 0.
- R3: An inject whose line lies inside an existing entry completes with status 0 and leaves the table unchanged, even when the table is full.
- R4: An inject or log into a table with no free slot completes with status 2 and leaves the table unchanged.
- R5: A clear (`req_op`=1) whose address plus 64 exceeds MEM_LINES*64 bytes completes with status 3 in the cycle after the request, without asserting `busy`.
- R6: A clear whose line is contained in no entry completes with status 0 and leaves the table unchanged.
- R7: A clear of a line inside an entry removes that line. If lines remain below it, they stay in the same slot with the same code. If lines remain above it, they go into the same slot when no lower part exists, and otherwise into the lowest free slot with the same code.
- R8: When the upper part of a split finds no free slot, it is dropped. Bit 1 of `rsp_flags` is then set and stays set until reset, `rsp_ovf_ts` takes the value of `ts_in` at that moment, and the clear completes with status 0.
- R9: A query (`req_op`=2) whose address has any of bits 5:0 set completes with status 1 and 0 records.
- R10: A query of start line Q and N lines emits one record per entry that overlaps [Q, Q+N), in ascending slot order. Each record carries the larger of the two start lines, times 64, with the origin code in address bits 2:0, and the number of overlapping lines. The completion reports the record count.
- R11: Log (`req_op`=3) adds an entry of `req_lines` lines and origin code `req_type` in the lowest free slot with status 0; a zero line count completes with status 1.
- R12: An accepted scanning request holds `busy` high for exactly DEPTH+1 cycles, and `rsp_done` pulses in the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while not busy |
| req_op | input | 2 | 0 inject, 1 clear, 2 query, 3 log |
| req_addr | input | ADDR_W | Byte address of the line or query window start |
| req_lines | input | LEN_W | Query window or logged range length in lines |
| req_type | input | 3 | Origin code for log |
| ts_in | input | TS_W | Free-running timestamp |
| busy | output | 1 | Table scan in progress |
| rec_valid | output | 1 | Query record present |
| rec_addr | output | ADDR_W | Clipped start address with origin code in bits 2:0 |
| rec_lines | output | LEN_W | Overlap length in lines |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 3 | 0 ok, 1 bad input, 2 table full, 3 bad address |
| rsp_count | output | CNT_W | Records emitted by the last query |
| rsp_flags | output | 8 | Bit 1: overflow has occurred |
| rsp_ovf_ts | output | TS_W | Timestamp of the latest overflow |

## Verification
The embedded properties check on every cycle that completion never overlaps a scan and always follows the fall of `busy`. They also check that records appear only during a scan and are never empty, that the overflow flag never clears, that the two table write ports never target the same slot, and that an address error completes right after its request. Slot choice, split geometry, clipping of records to the window, and which status each corner case returns can only be shown by the bench scenarios, which compare query results with a slot-level model built from the requirements.

// File: rtl/poison_pkg.sv
`timescale 1ns/1ps
package poison_pkg;
    typedef enum logic [1:0] {
        OP_INJECT = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_QUERY  = 2'd2,
        OP_LOG    = 2'd3
    } pt_op_e;

    typedef enum logic [2:0] {
        ST_OK        = 3'd0,
        ST_BAD_INPUT = 3'd1,
        ST_LIMIT     = 3'd2,
        ST_BAD_ADDR  = 3'd3
    } pt_status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_FIN  = 2'd2
    } pt_phase_e;

    localparam logic [2:0] TYPE_INJECTED = 3'b010;
    localparam int LINE_SHIFT = 6;
endpackage

// File: rtl/poison_store.sv
`timescale 1ns/1ps
module poison_store #(
    parameter int DEPTH  = 256,
    parameter int LINE_W = 26,
    parameter int LEN_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [LINE_W-1:0] rd_start,
    output logic [LEN_W-1:0]  rd_len,
    output logic [2:0]        rd_type,
    input  logic              w0_en,
    input  logic [IDX_W-1:0]  w0_idx,
    input  logic              w0_valid,
    input  logic [LINE_W-1:0] w0_start,
    input  logic [LEN_W-1:0]  w0_len,
    input  logic [2:0]        w0_type,
    input  logic              w1_en,
    input  logic [IDX_W-1:0]  w1_idx,
    input  logic [LINE_W-1:0] w1_start,
    input  logic [LEN_W-1:0]  w1_len,
    input  logic [2:0]        w1_type
);
    logic              valid_q [DEPTH];
    logic [LINE_W-1:0] start_q [DEPTH];
    logic [LEN_W-1:0]  len_q   [DEPTH];
    logic [2:0]        type_q  [DEPTH];

    assign rd_valid = valid_q[rd_idx];
    assign rd_start = start_q[rd_idx];
    assign rd_len   = len_q[rd_idx];
    assign rd_type  = type_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) valid_q[i] <= 1'b0;
        end else begin
            if (w0_en) valid_q[w0_idx] <= w0_valid;
            if (w1_en) valid_q[w1_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (w0_en) begin
            start_q[w0_idx] <= w0_start;
            len_q[w0_idx]   <= w0_len;
            type_q[w0_idx]  <= w0_type;
        end
        if (w1_en) begin
            start_q[w1_idx] <= w1_start;
            len_q[w1_idx]   <= w1_len;
            type_q[w1_idx]  <= w1_type;
        end
    end

    // R7
    dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w0_en && w1_en) |-> (w0_idx != w1_idx));
endmodule

// File: rtl/poison_span.sv
`timescale 1ns/1ps
module poison_span #(
    parameter int LINE_W = 26,
    parameter int LEN_W  = 16
) (
    input  logic [LINE_W-1:0] ent_start,
    input  logic [LEN_W-1:0]  ent_len,
    input  logic [LINE_W-1:0] pt_line,
    input  logic [LINE_W-1:0] win_start,
    input  logic [LEN_W-1:0]  win_lines,
    output logic              contains,
    output logic              overlaps,
    output logic [LINE_W-1:0] clip_start,
    output logic [LEN_W-1:0]  clip_lines,
    output logic              has_head,
    output logic [LEN_W-1:0]  head_len,
    output logic              has_tail,
    output logic [LINE_W-1:0] tail_start,
    output logic [LEN_W-1:0]  tail_len
);
    localparam int EW = LINE_W + 1;

    logic [EW-1:0] ent_end, pt_end, win_end, clip_end;

    always_comb begin
        ent_end  = {1'b0, ent_start} + EW'(ent_len);
        pt_end   = {1'b0, pt_line} + EW'(1);
        win_end  = {1'b0, win_start} + EW'(win_lines);

        contains = (pt_line >= ent_start) && ({1'b0, pt_line} < ent_end);
        overlaps = (ent_end > {1'b0, win_start}) && ({1'b0, ent_start} < win_end);

        clip_start = (ent_start > win_start) ? ent_start : win_start;
        clip_end   = (ent_end < win_end) ? ent_end : win_end;
        clip_lines = LEN_W'(clip_end - {1'b0, clip_start});

        has_head   = pt_line > ent_start;
        head_len   = LEN_W'(pt_line - ent_start);
        has_tail   = pt_end < ent_end;
        tail_start = pt_line + LINE_W'(1);
        tail_len   = LEN_W'(ent_end - pt_end);
    end
endmodule

// File: rtl/poison_table.sv
`timescale 1ns/1ps
module poison_table
    import poison_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int TS_W      = 64,
    parameter int DEPTH     = 256,
    parameter int MEM_LINES = 1 << 20,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_lines,
    input  logic [2:0]        req_type,
    input  logic [TS_W-1:0]   ts_in,
    output logic              busy,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [LEN_W-1:0]  rec_lines,
    output logic              rsp_done,
    output logic [2:0]        rsp_status,
    output logic [CNT_W-1:0]  rsp_count,
    output logic [7:0]        rsp_flags,
    output logic [TS_W-1:0]   rsp_ovf_ts
);
    localparam int LINE_W = ADDR_W - LINE_SHIFT;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam logic [ADDR_W:0] MEM_BYTES = (ADDR_W + 1)'(MEM_LINES) << LINE_SHIFT;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        pt_phase_e         phase;
        pt_op_e            op;
        logic [LINE_W-1:0] line;
        logic [LEN_W-1:0]  qlines;
        logic [2:0]        rtype;
        logic [IDX_W-1:0]  idx;
        logic              hit;
        logic [IDX_W-1:0]  hit_idx;
        logic [LINE_W-1:0] hit_start;
        logic [LEN_W-1:0]  hit_len;
        logic [2:0]        hit_type;
        logic              free_ok;
        logic [IDX_W-1:0]  free_idx;
        logic [CNT_W-1:0]  count;
        logic              ovf;
        logic [TS_W-1:0]   ovf_ts;
        logic              done;
        logic [2:0]        status;
        logic [CNT_W-1:0]  rsp_count;
        logic              rec_valid;
        logic [ADDR_W-1:0] rec_addr;
        logic [LEN_W-1:0]  rec_lines;
    } tbl_state_t;

    tbl_state_t s_d, s_q;

    // table ports
    logic              rd_valid;
    logic [LINE_W-1:0] rd_start;
    logic [LEN_W-1:0]  rd_len;
    logic [2:0]        rd_type;
    logic              w0_en, w0_valid, w1_en;
    logic [IDX_W-1:0]  w0_idx, w1_idx;
    logic [LINE_W-1:0] w0_start, w1_start;
    logic [LEN_W-1:0]  w0_len, w1_len;
    logic [2:0]        w0_type, w1_type;

    // span calculator ports
    logic [LINE_W-1:0] sp_start, sp_clip_start, sp_tail_start;
    logic [LEN_W-1:0]  sp_len, sp_clip_lines, sp_head_len, sp_tail_len;
    logic              sp_contains, sp_overlaps, sp_has_head, sp_has_tail;

    poison_store #(.DEPTH(DEPTH), .LINE_W(LINE_W), .LEN_W(LEN_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(s_q.idx), .rd_valid(rd_valid), .rd_start(rd_start),
        .rd_len(rd_len), .rd_type(rd_type),
        .w0_en(w0_en), .w0_idx(w0_idx), .w0_valid(w0_valid),
        .w0_start(w0_start), .w0_len(w0_len), .w0_type(w0_type),
        .w1_en(w1_en), .w1_idx(w1_idx),
        .w1_start(w1_start), .w1_len(w1_len), .w1_type(w1_type)
    );

    // In the final cycle the captured hit entry is measured, otherwise the slot being read.
    assign sp_start = (s_q.phase == PH_FIN) ? s_q.hit_start : rd_start;
    assign sp_len   = (s_q.phase == PH_FIN) ? s_q.hit_len   : rd_len;

    poison_span #(.LINE_W(LINE_W), .LEN_W(LEN_W)) u_span (
        .ent_start(sp_start), .ent_len(sp_len), .pt_line(s_q.line),
        .win_start(s_q.line), .win_lines(s_q.qlines),
        .contains(sp_contains), .overlaps(sp_overlaps),
        .clip_start(sp_clip_start), .clip_lines(sp_clip_lines),
        .has_head(sp_has_head), .head_len(sp_head_len),
        .has_tail(sp_has_tail), .tail_start(sp_tail_start), .tail_len(sp_tail_len)
    );

    always_comb begin
        s_d           = s_q;
        s_d.done      = 1'b0;
        s_d.rec_valid = 1'b0;
        w0_en = 1'b0; w0_idx = '0; w0_valid = 1'b0; w0_start = '0; w0_len = '0; w0_type = '0;
        w1_en = 1'b0; w1_idx = '0; w1_start = '0; w1_len = '0; w1_type = '0;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.op        = pt_op_e'(req_op);
                    s_d.line      = req_addr[ADDR_W-1:LINE_SHIFT];
                    s_d.qlines    = req_lines;
                    s_d.rtype     = req_type;
                    s_d.idx       = '0;
                    s_d.hit       = 1'b0;
                    s_d.free_ok   = 1'b0;
                    s_d.count     = '0;
                    s_d.rsp_count = '0;
                    s_d.phase     = PH_SCAN;
                    if ((pt_op_e'(req_op) == OP_CLEAR) &&
                        (({1'b0, req_addr} + (ADDR_W + 1)'(64)) > MEM_BYTES)) begin
                        s_d.phase  = PH_IDLE;
                        s_d.done   = 1'b1;
                        s_d.status = ST_BAD_ADDR;
                    end else if (((pt_op_e'(req_op) == OP_QUERY) && (req_addr[LINE_SHIFT-1:0] != '0)) ||
                                 ((pt_op_e'(req_op) == OP_LOG) && (req_lines == '0))) begin
                        s_d.phase  = PH_IDLE;
                        s_d.done   = 1'b1;
                        s_d.status = ST_BAD_INPUT;
                    end
                end
            end

            PH_SCAN: begin
                if (rd_valid) begin
                    if ((s_q.op == OP_INJECT) && sp_contains) s_d.hit = 1'b1;
                    if ((s_q.op == OP_CLEAR) && sp_contains && !s_q.hit) begin
                        s_d.hit       = 1'b1;
                        s_d.hit_idx   = s_q.idx;
                        s_d.hit_start = rd_start;
                        s_d.hit_len   = rd_len;
                        s_d.hit_type  = rd_type;
                    end
                    if ((s_q.op == OP_QUERY) && sp_overlaps) begin
                        s_d.rec_valid = 1'b1;
                        s_d.rec_addr  = {sp_clip_start, 3'b000, rd_type};
                        s_d.rec_lines = sp_clip_lines;
                        s_d.count     = s_q.count + CNT_W'(1);
                    end
                end else if (!s_q.free_ok) begin
                    s_d.free_ok  = 1'b1;
                    s_d.free_idx = s_q.idx;
                end
                if (s_q.idx == LAST_IDX) s_d.phase = PH_FIN;
                else                     s_d.idx   = s_q.idx + IDX_W'(1);
            end

            PH_FIN: begin
                s_d.phase  = PH_IDLE;
                s_d.done   = 1'b1;
                s_d.status = ST_OK;
                unique case (s_q.op)
                    OP_INJECT: begin
                        if (!s_q.hit) begin
                            if (!s_q.free_ok) begin
                                s_d.status = ST_LIMIT;
                            end else begin
                                w0_en = 1'b1; w0_idx = s_q.free_idx; w0_valid = 1'b1;
                                w0_start = s_q.line; w0_len = LEN_W'(1); w0_type = TYPE_INJECTED;
                            end
                        end
                    end
                    OP_LOG: begin
                        if (!s_q.free_ok) begin
                            s_d.status = ST_LIMIT;
                        end else begin
                            w0_en = 1'b1; w0_idx = s_q.free_idx; w0_valid = 1'b1;
                            w0_start = s_q.line; w0_len = s_q.qlines; w0_type = s_q.rtype;
                        end
                    end
                    OP_CLEAR: begin
                        if (s_q.hit) begin
                            w0_en   = 1'b1;
                            w0_idx  = s_q.hit_idx;
                            w0_type = s_q.hit_type;
                            if (sp_has_head) begin
                                w0_valid = 1'b1; w0_start = s_q.hit_start; w0_len = sp_head_len;
                                if (sp_has_tail) begin
                                    if (s_q.free_ok) begin
                                        w1_en = 1'b1; w1_idx = s_q.free_idx;
                                        w1_start = sp_tail_start; w1_len = sp_tail_len;
                                        w1_type = s_q.hit_type;
                                    end else begin
                                        s_d.ovf    = 1'b1;
                                        s_d.ovf_ts = ts_in;
                                    end
                                end
                            end else if (sp_has_tail) begin
                                w0_valid = 1'b1; w0_start = sp_tail_start; w0_len = sp_tail_len;
                            end
                        end
                    end
                    default: s_d.rsp_count = s_q.count;
                endcase
            end

            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.phase != PH_IDLE);
    assign rec_valid  = s_q.rec_valid;
    assign rec_addr   = s_q.rec_addr;
    assign rec_lines  = s_q.rec_lines;
    assign rsp_done   = s_q.done;
    assign rsp_status = s_q.status;
    assign rsp_count  = s_q.rsp_count;
    assign rsp_flags  = {6'b0, s_q.ovf, 1'b0};
    assign rsp_ovf_ts = s_q.ovf_ts;

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !busy);
    // R12
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_done);
    // R10
    rec_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (busy && (rec_lines != '0)));
    // R10
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_count <= CNT_W'(DEPTH)));
    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_flags[1] |=> rsp_flags[1]);
    // R5
    early_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && (rsp_status == ST_BAD_ADDR)) |-> $past(req_valid && !busy));
endmodule

// File: tb/sim_poison_table.sv
`timescale 1ns/1ps
module sim_poison_table;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int TS_W   = 64;
    localparam int DEPTH  = 8;
    localparam int MEML   = 64;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_lines = '0;
    logic [2:0]        req_type = '0;
    logic [TS_W-1:0]   ts_in = '0;
    logic              busy, rec_valid, rsp_done;
    logic [ADDR_W-1:0] rec_addr;
    logic [LEN_W-1:0]  rec_lines;
    logic [2:0]        rsp_status;
    logic [CNT_W-1:0]  rsp_count;
    logic [7:0]        rsp_flags;
    logic [TS_W-1:0]   rsp_ovf_ts;

    always #4 clk = ~clk;

    poison_table #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TS_W(TS_W),
                   .DEPTH(DEPTH), .MEM_LINES(MEML)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_lines(req_lines), .req_type(req_type),
        .ts_in(ts_in), .busy(busy), .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_lines(rec_lines), .rsp_done(rsp_done), .rsp_status(rsp_status),
        .rsp_count(rsp_count), .rsp_flags(rsp_flags), .rsp_ovf_ts(rsp_ovf_ts)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // reference table
    bit       mv [DEPTH];
    int       ms [DEPTH];
    int       ml [DEPTH];
    int       mt [DEPTH];
    bit       m_ovf;
    longint   m_ovf_ts;

    // results of the last operation
    int       got_n;
    int       got_addr [DEPTH];
    int       got_lines [DEPTH];
    int       got_status;
    int       got_busy;
    int       got_count;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; ms[i] = 0; ml[i] = 0; mt[i] = 0; end
        m_ovf = 0; m_ovf_ts = 0;
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < DEPTH; i++) if (!mv[i]) return i;
        return -1;
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_clear();
    endtask

    task automatic run_op(input int op, input int addr, input int lines, input int typ);
        got_n = 0; got_busy = 0;
        req_op = 2'(op); req_addr = ADDR_W'(addr); req_lines = LEN_W'(lines);
        req_type = 3'(typ); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (busy) got_busy++;
            if (rec_valid && got_n < DEPTH) begin
                got_addr[got_n] = int'(rec_addr); got_lines[got_n] = int'(rec_lines); got_n++;
            end
            if (rsp_done) break;
            @(negedge clk);
        end
        got_status = int'(rsp_status);
        got_count  = int'(rsp_count);
        @(negedge clk);
    endtask

    // reference operations, following the requirements
    task automatic ref_inject(input int line, output int st);
        int f;
        for (int i = 0; i < DEPTH; i++)
            if (mv[i] && line >= ms[i] && line < ms[i] + ml[i]) begin st = 0; return; end
        f = lowest_free();
        if (f < 0) begin st = 2; return; end
        mv[f] = 1; ms[f] = line; ml[f] = 1; mt[f] = 2; st = 0;
    endtask

    task automatic ref_log(input int line, input int n, input int t, output int st);
        int f;
        if (n == 0) begin st = 1; return; end
        f = lowest_free();
        if (f < 0) begin st = 2; return; end
        mv[f] = 1; ms[f] = line; ml[f] = n; mt[f] = t; st = 0;
    endtask

    task automatic ref_clear(input int addr, output int st);
        int line, h, f, s, e;
        line = addr / 64;
        if (addr + 64 > MEML * 64) begin st = 3; return; end
        st = 0; h = -1;
        for (int i = 0; i < DEPTH; i++)
            if (h < 0 && mv[i] && line >= ms[i] && line < ms[i] + ml[i]) h = i;
        if (h < 0) return;
        f = lowest_free(); s = ms[h]; e = ms[h] + ml[h];
        if (line > s) begin
            ml[h] = line - s;
            if (line + 1 < e) begin
                if (f >= 0) begin mv[f] = 1; ms[f] = line + 1; ml[f] = e - line - 1; mt[f] = mt[h]; end
                else begin m_ovf = 1; m_ovf_ts = longint'(ts_in); end
            end
        end else if (line + 1 < e) begin
            ms[h] = line + 1; ml[h] = e - line - 1;
        end else begin
            mv[h] = 0;
        end
    endtask

    task automatic do_inject(input string req, input int addr);
        int st;
        ref_inject(addr / 64, st);
        run_op(0, addr, 0, 0);
        chk(got_status == st, req, "inject status", got_status, st);
    endtask

    task automatic do_log(input string req, input int line, input int n, input int t);
        int st;
        ref_log(line, n, t, st);
        run_op(3, line * 64, n, t);
        chk(got_status == st, req, "log status", got_status, st);
    endtask

    task automatic do_clear(input string req, input int addr);
        int st;
        ref_clear(addr, st);
        run_op(1, addr, 0, 0);
        chk(got_status == st, req, "clear status", got_status, st);
    endtask

    task automatic q_check(input string req, input int qline, input int n);
        int exp_n, s, e, ea, el;
        run_op(2, qline * 64, n, 0);
        chk(got_status == 0, req, "query status", got_status, 0);
        exp_n = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mv[i] && ms[i] < qline + n && ms[i] + ml[i] > qline) begin
                s  = (ms[i] > qline) ? ms[i] : qline;
                e  = (ms[i] + ml[i] < qline + n) ? ms[i] + ml[i] : qline + n;
                ea = s * 64 + mt[i];
                el = e - s;
                if (exp_n < got_n) begin
                    chk(got_addr[exp_n] == ea, req, "record address", got_addr[exp_n], ea);
                    chk(got_lines[exp_n] == el, req, "record lines", got_lines[exp_n], el);
                end
                exp_n++;
            end
        end
        chk(got_n == exp_n, req, "records streamed", got_n, exp_n);
        chk(got_count == exp_n, req, "reported count", got_count, exp_n);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        apply_reset();
        chk(!busy, "R1", "busy after reset", busy, 0);
        chk(!rsp_done && !rec_valid, "R1", "done/rec after reset", {rsp_done, rec_valid}, 0);
        chk(rsp_flags == 0, "R1", "flags after reset", rsp_flags, 0);
        q_check("R1", 0, MEML);
    endtask

    task automatic t_inject();
        apply_reset();
        do_inject("R2", 'h100);
        chk(got_busy == DEPTH + 1, "R12", "busy cycles", got_busy, DEPTH + 1);
        do_inject("R2", 'h1C0);
        q_check("R2", 0, MEML);
        do_inject("R3", 'h108);
        q_check("R3", 0, MEML);
    endtask

    task automatic t_log_split();
        apply_reset();
        do_log("R11", 20, 10, 5);
        do_log("R11", 40, 0, 1);
        chk(got_busy == 0, "R11", "zero-length log busy", got_busy, 0);
        q_check("R11", 0, MEML);
        do_inject("R7", 0);
        do_clear("R7", 20 * 64);
        q_check("R7", 0, MEML);
        do_clear("R7", 25 * 64);
        q_check("R7", 0, MEML);
        q_check("R10", 22, 6);
        q_check("R10", 29, 1);
        do_clear("R6", 50 * 64);
        q_check("R6", 0, MEML);
    endtask

    task automatic t_bad_addr();
        apply_reset();
        do_clear("R5", MEML * 64 - 64);
        do_clear("R5", MEML * 64 - 63);
        chk(got_busy == 0, "R5", "busy on bad address", got_busy, 0);
        do_clear("R5", MEML * 64);
    endtask

    task automatic t_bad_query();
        apply_reset();
        do_inject("R9", 'h100);
        run_op(2, 'h104, 4, 0);
        chk(got_status == 1, "R9", "misaligned query status", got_status, 1);
        chk(got_n == 0 && got_count == 0, "R9", "misaligned query records", got_n, 0);
    endtask

    task automatic t_full();
        apply_reset();
        for (int i = 0; i < DEPTH; i++) do_inject("R2", i * 128);
        do_inject("R4", 'h40);
        do_log("R4", 30, 2, 3);
        q_check("R4", 0, MEML);
        do_inject("R3", 3 * 128);
        q_check("R3", 0, MEML);
    endtask

    task automatic t_overflow();
        apply_reset();
        do_log("R8", 30, 5, 1);
        for (int i = 0; i < DEPTH - 1; i++) do_inject("R8", i * 64);
        chk(rsp_flags == 0, "R8", "flags before overflow", rsp_flags, 0);
        ts_in = 64'h0000_1234_5678_9ABC;
        do_clear("R8", 32 * 64);
        chk(rsp_flags == 8'h02, "R8", "overflow flag", rsp_flags, 2);
        chk(rsp_ovf_ts == m_ovf_ts, "R8", "overflow timestamp", rsp_ovf_ts, m_ovf_ts);
        q_check("R8", 0, MEML);
        ts_in = 64'h0000_0000_0000_0077;
        do_inject("R8", 31 * 64);
        chk(rsp_flags == 8'h02, "R8", "flag held", rsp_flags, 2);
        chk(rsp_ovf_ts == 64'h0000_1234_5678_9ABC, "R8", "timestamp held",
            rsp_ovf_ts, 64'h0000_1234_5678_9ABC);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        model_clear();
        t_reset_state();
        t_inject();
        t_log_split();
        t_bad_addr();
        t_bad_query();
        t_full();
        t_overflow();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule